// File: doc/BRIEF.md
# Endpoint 0 Interrupt Flag Register

This block holds the interrupt status word that firmware polls or services for endpoint 0 of a USB function controller. Three single-cycle event strobes from the protocol engine (OUT packet accepted, IN token met with an empty FIFO, IN packet acknowledged) each latch a sticky flag. A fourth bit mirrors the VBUS pin level after a two-flop synchronizer. That bit is live status: it cannot be latched or cleared.

A second register holds one enable bit per status bit. The single interrupt line is the OR of every status bit ANDed with its enable. Firmware clears a flag by writing a word with 0 in that bit and 1 in every other bit. This lets one event be acknowledged without a read-modify-write race against events that arrive in the meantime. The register port is a plain select/write strobe with a one-bit address and a combinational read path.

Top module: `usb_ep0_irq_flags`

## Requirements
- R1: A one-cycle pulse on `ev_out_rx` sets status bit 2 at the next clock edge, and the bit stays set until cleared.
- R2: A one-cycle pulse on `ev_in_req` sets status bit 1 at the next clock edge, and the bit stays set until cleared.
- R3: A one-cycle pulse on `ev_in_done` sets status bit 0 at the next clock edge, and the bit stays set until cleared.
- R4: A write to address 0 clears each of bits 2..0 whose written value is 0 and leaves unchanged each bit whose written value is 1.
- R5: When an event pulse and a clearing write to the same bit fall in the same cycle, the bit ends up set.
- R6: Status bit 3 shows the `vbus_pin` level (1 connected, 0 disconnected) two clock edges after the pin changes, and no write changes it.
- R7: Address 1 holds a read/write enable in bits 3..0, which resets to 0. `irq` is high exactly when some status bit 3..0 and its enable bit are both 1.
- R8: Bits 7..4 read as 0 at both addresses, whatever value is written to them.
- R9: While `rst_n` is low, flags 2..0 and the enable clear to 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| vbus_pin | input | 1 | Raw VBUS detect pin level |
| ev_out_rx | input | 1 | Endpoint 0 OUT data accepted and ACKed (pulse) |
| ev_in_req | input | 1 | Endpoint 0 IN token with no transmit data (pulse) |
| ev_in_done | input | 1 | Endpoint 0 IN data sent and ACKed by host (pulse) |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write strobe, qualified by reg_sel |
| reg_addr | input | 1 | 0 = status word, 1 = enable word |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed word |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
A flag that is dropped or stuck shows up on the very next status read, and on `irq` in the same cycle once its enable is set. Because of this, each event and clear is followed at once by a read and an interrupt-line comparison. The bench targets a write-0-to-clear that also touches the bits written with 1, and an event lost to a colliding clear. These show as a wrong bit one cycle after the write. A synchronizer of the wrong depth shows as the VBUS bit changing one edge early or late. It is caught by sampling after each of the two edges.

// File: rtl/ep0irq_pkg.sv
package ep0irq_pkg;
  localparam int unsigned WORD_W      = 8;
  localparam int unsigned NUM_EVT     = 3;
  localparam int unsigned STAT_W      = NUM_EVT + 1;
  localparam int unsigned VBUS_BIT    = NUM_EVT;
  localparam int unsigned SYNC_STAGES = 2;
  // status bit positions, decoded by firmware
  localparam int unsigned BIT_IN_DONE = 0;
  localparam int unsigned BIT_IN_REQ  = 1;
  localparam int unsigned BIT_OUT_RX  = 2;
  localparam logic        ADDR_STAT   = 1'b0;
  localparam logic        ADDR_EN     = 1'b1;
endpackage

// File: rtl/ep0irq_sync.sv
module ep0irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] age_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
      end
      // R6: output is the pin value two edges earlier
      p_vbus_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (dout == $past(din, 2)));
    end
  endgenerate
endmodule

// File: rtl/ep0irq_flag.sv
module ep0irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic q
);
  logic q_nxt;
  logic q_ce;

  always_comb begin
    q_ce  = evt | clr;
    q_nxt = evt | (q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_ce) q <= q_nxt;
  end

  // R1 R2 R3: an event leaves the flag set
  p_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> q);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !q);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !evt) |=> $stable(q));
  p_evt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt) |=> q);
endmodule

// File: rtl/ep0irq_enable.sv
module ep0irq_enable #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en
);
  logic [W-1:0] en_nxt;

  always_comb begin
    en_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en <= '0;
    else if (we) en <= en_nxt;
  end

  p_en_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (en == $past(wdata)));
  p_en_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(en));
endmodule

// File: rtl/usb_ep0_irq_flags.sv
module usb_ep0_irq_flags
  import ep0irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vbus_pin,
  input  logic              ev_out_rx,
  input  logic              ev_in_req,
  input  logic              ev_in_done,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int unsigned PAD_W = WORD_W - STAT_W;

  logic [NUM_EVT-1:0] evt_vec;
  logic [NUM_EVT-1:0] clr_vec;
  logic [NUM_EVT-1:0] flag_vec;
  logic [STAT_W-1:0]  status;
  logic [STAT_W-1:0]  en;
  logic               vbus_s;
  logic               wr_stat;
  logic               wr_en;

  always_comb begin
    evt_vec              = '0;
    evt_vec[BIT_IN_DONE] = ev_in_done;
    evt_vec[BIT_IN_REQ]  = ev_in_req;
    evt_vec[BIT_OUT_RX]  = ev_out_rx;
    wr_stat = reg_sel & reg_wr & (reg_addr == ADDR_STAT);
    wr_en   = reg_sel & reg_wr & (reg_addr == ADDR_EN);
  end

  ep0irq_sync #(.STAGES(SYNC_STAGES)) u_vbus_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (vbus_pin),
    .dout (vbus_s)
  );

  generate
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
      assign clr_vec[i] = wr_stat & ~reg_wdata[i];
      ep0irq_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (evt_vec[i]),
        .clr  (clr_vec[i]),
        .q    (flag_vec[i])
      );
    end
  endgenerate

  ep0irq_enable #(.W(STAT_W)) u_enable (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_en),
    .wdata(reg_wdata[STAT_W-1:0]),
    .en   (en)
  );

  always_comb begin
    status = {vbus_s, flag_vec};
    irq    = |(status & en);
    if (reg_addr == ADDR_EN) reg_rdata = {{PAD_W{1'b0}}, en};
    else                     reg_rdata = {{PAD_W{1'b0}}, status};
  end

  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[WORD_W-1:STAT_W] == '0);
  p_vbus_unclearable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !reg_wdata[VBUS_BIT] && $past(vbus_pin) && vbus_s) |=> vbus_s);
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n |-> (flag_vec == '0 && en == '0 && !irq));
endmodule

// File: tb/usb_ep0_irq_flags_tb.sv
module usb_ep0_irq_flags_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct {
    logic       addr;
    logic [7:0] data;
    logic       irq;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n, vbus_pin, ev_out_rx, ev_in_req, ev_in_done;
  logic reg_sel, reg_wr, reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic irq;

  item_t sb_q[$];
  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  logic [2:0] m_flags;
  logic [3:0] m_en;
  logic       m_vbus;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ep0_irq_flags u_dut (
    .clk(clk), .rst_n(rst_n), .vbus_pin(vbus_pin),
    .ev_out_rx(ev_out_rx), .ev_in_req(ev_in_req), .ev_in_done(ev_in_done),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // monitor: compare against the expected item at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      vectors++;
      if (reg_rdata !== it.data || irq !== it.irq) begin
        miscompares++;
        $display("FAIL %s: addr=%0d rdata=%02h irq=%b expected rdata=%02h irq=%b",
                 it.tag, it.addr, reg_rdata, irq, it.data, it.irq);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  // push the expected value of one register read, monitor checks it
  task automatic expect_rd(input logic addr, input string tag);
    item_t it;
    logic [3:0] st;
    st = {m_vbus, m_flags};
    reg_addr = addr;
    reg_sel  = 1'b0;
    reg_wr   = 1'b0;
    it.addr = addr;
    it.data = addr ? {4'h0, m_en} : {4'h0, st};
    it.irq  = |(st & m_en);
    it.tag  = tag;
    sb_q.push_back(it);
    step();
  endtask

  task automatic pulse(input logic [2:0] ev);
    {ev_out_rx, ev_in_req, ev_in_done} = ev;
    m_flags = m_flags | ev;
    step();
    {ev_out_rx, ev_in_req, ev_in_done} = 3'b000;
  endtask

  task automatic wr(input logic addr, input logic [7:0] d, input logic [2:0] ev);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = addr; reg_wdata = d;
    {ev_out_rx, ev_in_req, ev_in_done} = ev;
    if (addr) m_en = d[3:0];
    else      m_flags = (m_flags & d[2:0]) | ev;
    if (!addr && ev == 3'b000) m_flags = m_flags & d[2:0];
    step();
    reg_sel = 1'b0; reg_wr = 1'b0;
    {ev_out_rx, ev_in_req, ev_in_done} = 3'b000;
  endtask

  initial begin
    rst_n = 1'b0; vbus_pin = 1'b0;
    ev_out_rx = 0; ev_in_req = 0; ev_in_done = 0;
    reg_sel = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 8'h00;
    m_flags = 3'b000; m_en = 4'h0; m_vbus = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    expect_rd(1'b0, "R9 reset status");
    expect_rd(1'b1, "R9 reset enable");

    pulse(3'b100); expect_rd(1'b0, "R1 out-rx sets bit2");
    repeat (3) step(); expect_rd(1'b0, "R1 flag sticky");
    pulse(3'b010); expect_rd(1'b0, "R2 in-req sets bit1");
    pulse(3'b001); expect_rd(1'b0, "R3 in-done sets bit0");

    wr(1'b0, 8'hFD, 3'b000); expect_rd(1'b0, "R4 clear bit1 only");
    wr(1'b0, 8'hFF, 3'b000); expect_rd(1'b0, "R4 write ones no change");
    wr(1'b0, 8'hFA, 3'b000); expect_rd(1'b0, "R4 clear bit0 and bit2");

    pulse(3'b010);
    wr(1'b0, 8'hFD, 3'b010); expect_rd(1'b0, "R5 event beats clear");
    wr(1'b0, 8'hF8, 3'b100); expect_rd(1'b0, "R5 other bits cleared, bit2 kept");

    wr(1'b1, 8'hF5, 3'b000); expect_rd(1'b1, "R8 enable upper bits read 0");
    expect_rd(1'b0, "R7 irq from bit2");
    wr(1'b1, 8'h02, 3'b000); expect_rd(1'b0, "R7 irq off when unmatched");
    wr(1'b0, 8'hF0, 3'b000);
    pulse(3'b001); expect_rd(1'b0, "R7 no irq bit0 disabled");
    wr(1'b1, 8'h01, 3'b000); expect_rd(1'b0, "R7 irq bit0 enabled");
    wr(1'b0, 8'hF0, 3'b000); expect_rd(1'b0, "R4 all cleared irq drops");

    // VBUS two-edge latency
    vbus_pin = 1'b1; step();
    expect_rd(1'b0, "R6 vbus not yet after one edge");
    m_vbus = 1'b1;
    expect_rd(1'b0, "R6 vbus shown after two edges");
    wr(1'b0, 8'h00, 3'b000); expect_rd(1'b0, "R6 write 0 keeps vbus");
    wr(1'b0, 8'hF7, 3'b000); expect_rd(1'b0, "R8 upper write ignored");
    wr(1'b1, 8'h08, 3'b000); expect_rd(1'b0, "R7 irq from vbus");
    vbus_pin = 1'b0; step(); m_vbus = 1'b0; step();
    expect_rd(1'b0, "R6 vbus disconnect seen");

    pulse(3'b111); wr(1'b1, 8'h0F, 3'b000);
    rst_n = 1'b0; m_flags = 3'b000; m_en = 4'h0;
    #2;
    vectors++;
    if (irq !== 1'b0 || reg_rdata !== 8'h00) begin
      miscompares++;
      $display("FAIL R9 in reset: rdata=%02h irq=%b expected rdata=00 irq=0", reg_rdata, irq);
    end
    step(); rst_n = 1'b1; step();
    expect_rd(1'b0, "R9 status after second reset");
    expect_rd(1'b1, "R9 enable after second reset");

    step();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule